// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one down-counting timer channel with six operating modes, selected by a 3-bit mode code. The channel counts on a one-cycle count-enable pulse (the tick), not on every clock, so a slow count clock can be derived elsewhere and fed in as an enable. A gate input either permits counting or, in the triggered modes, starts a countdown on its rising edge. The channel drives one output line whose waveform depends on the mode: a timeout level, a triggered one-shot, a periodic one-tick low pulse, a square wave, or a single one-tick strobe.

A controller first writes the mode and the binary/decimal select, which puts the output at the idle level for that mode and stops counting. It then writes a 16-bit initial count, which arms the channel. The live count is always visible on a port, so an external register can capture it. A configuration write takes priority over a count write, and a count write takes priority over a tick in the same cycle.

Top module: `interval_timer_chan`

## Requirements
- R1: Mode 0 (timeout): a count write drives the output low and starts counting. Each tick with gate high decrements the count. Ticks with gate low leave it unchanged. When the count reaches zero the output goes high, and it stays high while counting continues to wrap, until the next configuration or count write.
- R2: Mode 1 (triggered one-shot): the output stays high and the count is frozen until a tick arrives with a gate rising edge pending. That tick loads the count and drives the output low. Each later tick decrements the count whatever the gate level. The output returns high on the tick that reaches zero, and the count then holds at zero until the next trigger.
- R3: Mode 2 (rate generator) with initial count N of 2 or more: with gate high, the output is low after tick k exactly when k mod N equals N-1, and high otherwise. While the gate is low, the count holds and the output is forced high at the next clock edge.
- R4: Mode 3 (square wave) with N of 2 or more: the count steps down by two per tick with gate high. Over each period of N ticks, the output is high for (N+1)/2 ticks (integer division) and low for the rest. Once a count is loaded, the readable count is always even.
- R5: Mode 4 (software strobe): after a count write, the output stays high until the tick that brings the count to zero. It is low for exactly one tick, then returns high. The count is not reloaded and stays at zero.
- R6: Mode 5 (hardware strobe): a tick with a gate rising edge pending loads the count. Later ticks decrement it whatever the gate level. The output is low for exactly one tick at zero and does not repeat.
- R7: When the decimal select is 1, the count is four BCD digits (bits 15:12 thousands down to bits 3:0 units) and decrements in decimal, so 0x0010 steps to 0x0009.
- R8: A loaded count of zero stands for the largest count: one tick gives 0xFFFF in binary and 0x9999 in decimal.
- R9: After reset the channel is in binary mode 0 with output low, count 0x0000 and no counting. A configuration write sets the output idle level (low for mode 0, high for all other modes) and suspends counting until the next count write.
- R10: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R11: The count changes only at a clock edge with a tick, a count write or a configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | One-cycle count tick |
| gate | input | 1 | Gate level |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Mode code for a configuration write |
| cfg_bcd | input | 1 | Decimal count select for a configuration write |
| load_wr | input | 1 | Initial count write strobe |
| load_val | input | 16 | Initial count |
| count_out | output | 16 | Live count |
| out_line | output | 1 | Channel output |

## Verification
On every cycle, the assertions check that the mode 0 output never falls on its own, that a low gate freezes the count in the gated modes, that the mode 3 count stays even, that each strobe pulse lasts one tick, and that the count moves only on a tick or a write. The bench scenarios cover the rest: the exact tick on which each output edge lands, the odd and even square-wave splits over random counts, decimal borrow and the zero-means-maximum wrap, trigger handling in modes 1 and 5, and the mode 6 and 7 aliases.

// File: rtl/itc_pkg.sv
package itc_pkg;

    parameter int CNT_W = 16;
    localparam int BCD_DIGITS = CNT_W / 4;
    localparam int unsigned BCD_MOD = 10 ** BCD_DIGITS;

    typedef enum logic [2:0] {
        M_TIMEOUT  = 3'd0,
        M_TRIG_OS  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SW_STRB  = 3'd4,
        M_HW_STRB  = 3'd5
    } tmr_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        tmr_mode_e        mode;
        logic             bcd;
        logic             out;
        logic             armed;
        logic             running;
    } chan_state_t;

    // Codes 6 and 7 fall back onto the rate and square-wave modes.
    function automatic tmr_mode_e fold_mode(input logic [2:0] code);
        tmr_mode_e m;
        case (code)
            3'd6:    m = M_RATE;
            3'd7:    m = M_SQUARE;
            default: m = tmr_mode_e'(code);
        endcase
        return m;
    endfunction

    function automatic int unsigned bcd_to_int(input logic [CNT_W-1:0] v);
        int unsigned acc;
        int unsigned scale;
        acc = 0;
        scale = 1;
        for (int i = 0; i < BCD_DIGITS; i++) begin
            acc = acc + 32'(v[4*i +: 4]) * scale;
            scale = scale * 10;
        end
        return acc;
    endfunction

    function automatic logic [CNT_W-1:0] int_to_bcd(input int unsigned n);
        logic [CNT_W-1:0] r;
        int unsigned rem;
        r = '0;
        rem = n;
        for (int i = 0; i < BCD_DIGITS; i++) begin
            r[4*i +: 4] = 4'(rem % 10);
            rem = rem / 10;
        end
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] dec_bcd(input logic [CNT_W-1:0] v,
                                                 input int unsigned amt);
        return int_to_bcd((bcd_to_int(v) + BCD_MOD - amt) % BCD_MOD);
    endfunction

    function automatic logic [CNT_W-1:0] inc_bcd(input logic [CNT_W-1:0] v);
        return int_to_bcd((bcd_to_int(v) + 1) % BCD_MOD);
    endfunction

endpackage

// File: rtl/itc_gate_edge.sv
module itc_gate_edge (
    input  logic clk,
    input  logic rst,
    input  logic gate,
    input  logic clr,
    input  logic consume,
    output logic trig
);
    logic gate_q;
    logic pend_q;
    logic rise;

    assign rise = gate & ~gate_q;
    assign trig = pend_q | rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            gate_q <= gate;
            if (clr || consume)
                pend_q <= 1'b0;
            else if (rise)
                pend_q <= 1'b1;
        end
    end
endmodule

// File: rtl/itc_arith.sv
module itc_arith
    import itc_pkg::*;
#(
    parameter bit HAS_BCD = 1'b1
) (
    input  logic [CNT_W-1:0] cur,
    input  logic [CNT_W-1:0] base,
    input  logic             bcd,
    input  logic             dbl,
    output logic [CNT_W-1:0] dec_val,
    output logic             dec_zero,
    output logic [CNT_W-1:0] sq_hi_start,
    output logic [CNT_W-1:0] sq_lo_start
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic [CNT_W-1:0] base_inc;
    logic [CNT_W-1:0] base_dec;

    generate
        if (HAS_BCD) begin : g_dual
            always_comb begin
                if (bcd) begin
                    dec_val  = dec_bcd(cur, dbl ? 2 : 1);
                    base_inc = inc_bcd(base);
                    base_dec = dec_bcd(base, 1);
                end else begin
                    dec_val  = cur - (dbl ? TWO : ONE);
                    base_inc = base + ONE;
                    base_dec = base - ONE;
                end
            end
        end else begin : g_bin
            always_comb begin
                dec_val  = cur - (dbl ? TWO : ONE);
                base_inc = base + ONE;
                base_dec = base - ONE;
            end
        end
    endgenerate

    assign dec_zero = (dec_val == '0);
    // An odd count lengthens the high half by one and shortens the low half.
    assign sq_hi_start = base[0] ? base_inc : base;
    assign sq_lo_start = base[0] ? base_dec : base;
endmodule

// File: rtl/interval_timer_chan.sv
module interval_timer_chan
    import itc_pkg::*;
#(
    parameter bit HAS_BCD = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             gate,
    input  logic             cfg_wr,
    input  logic [2:0]       cfg_mode,
    input  logic             cfg_bcd,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count_out,
    output logic             out_line
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    chan_state_t st_q;
    chan_state_t st_d;

    logic             trig;
    logic [CNT_W-1:0] dec_val;
    logic             dec_zero;
    logic [CNT_W-1:0] sq_hi;
    logic [CNT_W-1:0] sq_lo;
    logic [CNT_W-1:0] arith_base;
    tmr_mode_e        new_mode;

    assign arith_base = load_wr ? load_val : st_q.reload;
    assign new_mode   = fold_mode(cfg_mode);

    itc_gate_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .gate    (gate),
        .clr     (cfg_wr | load_wr),
        .consume (cnt_en),
        .trig    (trig)
    );

    itc_arith #(.HAS_BCD(HAS_BCD)) u_arith (
        .cur         (st_q.count),
        .base        (arith_base),
        .bcd         (st_q.bcd),
        .dbl         (st_q.mode == M_SQUARE),
        .dec_val     (dec_val),
        .dec_zero    (dec_zero),
        .sq_hi_start (sq_hi),
        .sq_lo_start (sq_lo)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.mode    = new_mode;
            st_d.bcd     = cfg_bcd;
            st_d.out     = (new_mode != M_TIMEOUT);
            st_d.armed   = 1'b0;
            st_d.running = 1'b0;
        end else if (load_wr) begin
            st_d.reload = load_val;
            st_d.armed  = 1'b1;
            case (st_q.mode)
                M_TIMEOUT: begin
                    st_d.count   = load_val;
                    st_d.out     = 1'b0;
                    st_d.running = 1'b1;
                end
                M_RATE, M_SW_STRB: begin
                    st_d.count   = load_val;
                    st_d.out     = 1'b1;
                    st_d.running = 1'b1;
                end
                M_SQUARE: begin
                    st_d.count   = sq_hi;
                    st_d.out     = 1'b1;
                    st_d.running = 1'b1;
                end
                default: begin
                    st_d.out     = 1'b1;
                    st_d.running = 1'b0;
                end
            endcase
        end else begin
            if (st_q.mode == M_RATE && !gate)
                st_d.out = 1'b1;
            if (cnt_en) begin
                case (st_q.mode)
                    M_TIMEOUT: begin
                        if (st_q.running && gate) begin
                            st_d.count = dec_val;
                            if (dec_zero)
                                st_d.out = 1'b1;
                        end
                    end
                    M_TRIG_OS: begin
                        if (trig && st_q.armed) begin
                            st_d.count   = st_q.reload;
                            st_d.out     = 1'b0;
                            st_d.running = 1'b1;
                        end else if (st_q.running) begin
                            st_d.count = dec_val;
                            if (dec_zero) begin
                                st_d.out     = 1'b1;
                                st_d.running = 1'b0;
                            end
                        end
                    end
                    M_RATE: begin
                        if (st_q.running && gate) begin
                            if (st_q.count == ONE) begin
                                st_d.count = st_q.reload;
                                st_d.out   = 1'b1;
                            end else begin
                                st_d.count = dec_val;
                                st_d.out   = (dec_val != ONE);
                            end
                        end
                    end
                    M_SQUARE: begin
                        if (st_q.running && gate) begin
                            if (dec_zero) begin
                                st_d.out   = ~st_q.out;
                                st_d.count = st_q.out ? sq_lo : sq_hi;
                            end else begin
                                st_d.count = dec_val;
                            end
                        end
                    end
                    M_SW_STRB: begin
                        if (st_q.running) begin
                            if (!st_q.out) begin
                                st_d.out     = 1'b1;
                                st_d.running = 1'b0;
                            end else if (gate) begin
                                st_d.count = dec_val;
                                if (dec_zero)
                                    st_d.out = 1'b0;
                            end
                        end
                    end
                    M_HW_STRB: begin
                        if (trig && st_q.armed) begin
                            st_d.count   = st_q.reload;
                            st_d.out     = 1'b1;
                            st_d.running = 1'b1;
                        end else if (st_q.running) begin
                            if (!st_q.out) begin
                                st_d.out     = 1'b1;
                                st_d.running = 1'b0;
                            end else begin
                                st_d.count = dec_val;
                                if (dec_zero)
                                    st_d.out = 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.count   <= '0;
            st_q.reload  <= '0;
            st_q.mode    <= M_TIMEOUT;
            st_q.bcd     <= 1'b0;
            st_q.out     <= 1'b0;
            st_q.armed   <= 1'b0;
            st_q.running <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_out = st_q.count;
    assign out_line  = st_q.out;
endmodule

// File: rtl/itc_checker.sv
module itc_checker
    import itc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             gate,
    input  logic             cfg_wr,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] count_out,
    input  logic             out_line,
    input  tmr_mode_e        mode_q,
    input  logic             armed_q
);
    logic quiet;
    logic strobe_mode;
    logic gated_mode;

    assign quiet       = !cfg_wr && !load_wr;
    assign strobe_mode = (mode_q == M_SW_STRB) || (mode_q == M_HW_STRB);
    assign gated_mode  = (mode_q == M_TIMEOUT) || (mode_q == M_RATE) ||
                         (mode_q == M_SQUARE)  || (mode_q == M_SW_STRB);

    assert_timeout_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_TIMEOUT && out_line && quiet) |=> out_line);

    assert_gate_halt_R3: assert property (@(posedge clk) disable iff (rst)
        (gated_mode && !gate && quiet) |=> $stable(count_out));

    assert_even_count_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_SQUARE && armed_q) |-> (count_out[0] == 1'b0));

    // Covers the hardware strobe (R6) as well.
    assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (strobe_mode && !out_line && cnt_en && quiet) |=> out_line);

    assert_strobe_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (strobe_mode && !out_line && !cnt_en && quiet) |=> !out_line);

    assert_tick_only_R11: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && quiet) |=> $stable(count_out));
endmodule

bind interval_timer_chan itc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (cnt_en),
    .gate      (gate),
    .cfg_wr    (cfg_wr),
    .load_wr   (load_wr),
    .count_out (count_out),
    .out_line  (out_line),
    .mode_q    (st_q.mode),
    .armed_q   (st_q.armed)
);

// File: tb/interval_timer_chan_tb.sv
`timescale 1ns/1ps
module interval_timer_chan_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic        gate = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_mode = 3'd0;
    logic        cfg_bcd = 1'b0;
    logic        load_wr = 1'b0;
    logic [15:0] load_val = 16'd0;
    logic [15:0] count_out;
    logic        out_line;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    interval_timer_chan u_dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .gate(gate),
        .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd),
        .load_wr(load_wr), .load_val(load_val),
        .count_out(count_out), .out_line(out_line)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        cnt_en = 1'b1;
        @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic configure(input logic [2:0] m, input logic b);
        cfg_mode = m; cfg_bcd = b; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic load(input logic [15:0] v);
        load_val = v; load_wr = 1'b1;
        @(negedge clk);
        load_wr = 1'b0;
    endtask

    function automatic bit exp_rate(input int n, input int k);
        return (k % n) != (n - 1);
    endfunction

    function automatic bit exp_square(input int n, input int k);
        return (k % n) < ((n + 1) / 2);
    endfunction

    task automatic run_rate(input string tag, input logic [2:0] code, input int n);
        gate = 1'b1;
        configure(code, 1'b0);
        load(16'(n));
        for (int k = 1; k <= 2 * n + 1; k++) begin
            tick();
            check(tag, out_line, exp_rate(n, k));
        end
    endtask

    task automatic run_square(input string tag, input logic [2:0] code, input int n);
        gate = 1'b1;
        configure(code, 1'b0);
        load(16'(n));
        check(tag, out_line, 1'b1);
        for (int k = 1; k <= 2 * n + 1; k++) begin
            tick();
            check(tag, out_line, exp_square(n, k));
            check({tag, " even"}, count_out[0], 1'b0);
        end
    endtask

    initial begin
        int n;
        int g_cnt;
        void'($urandom(32'd1234));
        idle(2);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        check("R9 reset out", out_line, 1'b0);
        check("R9 reset count", count_out, 16'h0000);
        ticks(2);
        check("R9 reset idle", count_out, 16'h0000);

        // R1 mode 0 directed
        n = 5 + int'($urandom_range(0, 30));
        gate = 1'b1;
        configure(3'd0, 1'b0);
        check("R9 mode0 idle level", out_line, 1'b0);
        load(16'(n));
        ticks(n - 1);
        check("R1 count before zero", count_out, 16'd1);
        check("R1 out before zero", out_line, 1'b0);
        gate = 1'b0;
        ticks(3);
        check("R1 gate low halts", count_out, 16'd1);
        idle(3);
        check("R11 no tick holds", count_out, 16'd1);
        gate = 1'b1;
        tick();
        check("R1 zero count", count_out, 16'd0);
        check("R1 out high at zero", out_line, 1'b1);
        tick();
        check("R1 wraps and stays high", {count_out, 15'd0, out_line}, {16'hFFFF, 15'd0, 1'b1});

        // R1 random gate pattern
        for (int it = 0; it < 4; it++) begin
            n = 20 + int'($urandom_range(0, 40));
            configure(3'd0, 1'b0);
            load(16'(n));
            g_cnt = 0;
            for (int k = 0; k < 50; k++) begin
                gate = 1'($urandom_range(0, 1));
                if (gate) g_cnt++;
                tick();
            end
            check("R1 random count", count_out, 16'(n - g_cnt));
            check("R1 random out", out_line, (g_cnt >= n) ? 1'b1 : 1'b0);
        end

        // R9: a configuration write suspends counting until a load
        gate = 1'b1;
        configure(3'd0, 1'b0);
        ticks(4);
        check("R9 no count before load", count_out, 16'(n - g_cnt));

        // R8 / R7
        configure(3'd0, 1'b0);
        load(16'h0000);
        tick();
        check("R8 binary zero is max", count_out, 16'hFFFF);
        configure(3'd0, 1'b1);
        load(16'h0000);
        tick();
        check("R8 bcd zero is max", count_out, 16'h9999);
        load(16'h0010);
        tick();
        check("R7 bcd borrow", count_out, 16'h0009);
        ticks(2);
        check("R7 bcd step", count_out, 16'h0007);
        load(16'h1000);
        tick();
        check("R7 bcd multi borrow", count_out, 16'h0999);

        // R2 mode 1
        n = 4 + int'($urandom_range(0, 10));
        gate = 1'b0;
        configure(3'd1, 1'b0);
        check("R9 mode1 idle level", out_line, 1'b1);
        load(16'(n));
        ticks(3);
        check("R2 waits for trigger", out_line, 1'b1);
        gate = 1'b1;
        tick();
        check("R2 trigger out low", out_line, 1'b0);
        check("R2 trigger loads", count_out, 16'(n));
        gate = 1'b0;
        ticks(n - 1);
        check("R2 gate low keeps counting", count_out, 16'd1);
        check("R2 still low", out_line, 1'b0);
        tick();
        check("R2 high at zero", out_line, 1'b1);
        ticks(3);
        check("R2 no reload", {count_out, 15'd0, out_line}, {16'd0, 15'd0, 1'b1});
        gate = 1'b1;
        tick();
        check("R2 retrigger", {count_out, 15'd0, out_line}, {16'(n), 15'd0, 1'b0});

        // R3 mode 2
        for (int it = 0; it < 3; it++) run_rate("R3 rate out", 3'd2, 2 + int'($urandom_range(0, 14)));
        n = 6;
        configure(3'd2, 1'b0);
        load(16'(n));
        ticks(n - 1);
        check("R3 low before gate drop", out_line, 1'b0);
        gate = 1'b0;
        idle(1);
        check("R3 gate low forces high", out_line, 1'b1);
        ticks(2);
        check("R3 gate low halts", count_out, 16'd1);

        // R4 mode 3, odd and even counts
        run_square("R4 square even", 3'd3, 8);
        run_square("R4 square odd", 3'd3, 7);
        for (int it = 0; it < 4; it++) run_square("R4 square rnd", 3'd3, 2 + int'($urandom_range(0, 20)));

        // R5 mode 4
        n = 3 + int'($urandom_range(0, 10));
        gate = 1'b1;
        configure(3'd4, 1'b0);
        load(16'(n));
        ticks(n - 1);
        check("R5 high before zero", out_line, 1'b1);
        tick();
        check("R5 low at zero", {count_out, 15'd0, out_line}, {16'd0, 15'd0, 1'b0});
        idle(2);
        check("R5 low held between ticks", out_line, 1'b0);
        tick();
        check("R5 pulse one tick", out_line, 1'b1);
        ticks(4);
        check("R5 no reload", {count_out, 15'd0, out_line}, {16'd0, 15'd0, 1'b1});

        // R6 mode 5
        n = 3 + int'($urandom_range(0, 10));
        gate = 1'b0;
        configure(3'd5, 1'b0);
        load(16'(n));
        ticks(3);
        check("R6 waits for trigger", out_line, 1'b1);
        gate = 1'b1;
        tick();
        check("R6 trigger loads", count_out, 16'(n));
        gate = 1'b0;
        ticks(n - 1);
        check("R6 high before zero", {count_out, 15'd0, out_line}, {16'd1, 15'd0, 1'b1});
        tick();
        check("R6 low at zero", out_line, 1'b0);
        tick();
        check("R6 pulse one tick", out_line, 1'b1);
        ticks(3);
        check("R6 no repeat", {count_out, 15'd0, out_line}, {16'd0, 15'd0, 1'b1});

        // R10 aliases
        run_rate("R10 code 6 as rate", 3'd6, 3);
        run_square("R10 code 7 as square", 3'd7, 4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule